// File: doc/BRIEF.md
# Use-Count Managed Register Cache

This block is a small set-associative cache of physical register values, placed in front of a large register file so that operand reads can be served quickly. Each resident entry keeps the full physical register number as its tag, the 32-bit value and a count of the consumers that still have to read it. A write-back port offers a new value together with the number of consumers a predictor expects and the number the bypass network has already served. Only the remainder is kept as the entry's count. A value that has no remaining consumers is never written into the cache, so it cannot push out anything useful.

The set that receives a value is chosen by an external allocator and arrives with the write-back. A per-register map remembers that choice, so later reads find the right set without taking any bits of the register number. Read ports answer in the same cycle with a hit flag and the data. Each hit uses up one count, and an entry whose count reaches zero drops out. When a set is full, the entry with the fewest remaining uses is replaced. A free input removes an entry whose count was set too high, when its register is released at retirement.

The write-back interface is valid/ready. `wb_ready` is held high at all times, so a write-back is taken in every cycle in which `wb_valid` is high, and no back-pressure is ever applied. Reads and frees are plain strobes.

Top module: `regcache_usecount`

## Requirements
- R1: The count stored on insertion is `wb_pred - wb_byp` when `wb_pred > wb_byp`. When `wb_pred <= wb_byp` the value is not inserted, and a later read of that register misses.
- R2: A value goes into the set given by `wb_set`, and its tag is the full register number. Registers whose numbers share low bits can be resident together if they are given different sets. A read that hits returns exactly the value that was written.
- R3: When the target set has an invalid way, the lowest-numbered invalid way is filled, and no valid entry is evicted.
- R4: When the target set is full, the way with the smallest remaining count is replaced. A tie goes to the lowest-numbered way.
- R5: `rd_hit[p]` is 1 in the same cycle only if `rd_valid[p]` is high and the register is resident. On a miss, `rd_data` for that port is all zeros.
- R6: Each read hit lowers the entry's count by one at the clock edge. Two ports hitting the same register in one cycle lower it by two. An entry whose count reaches zero becomes invalid and misses from then on.
- R7: A `free_valid` strobe invalidates the entry holding `free_preg`. If a read hits that register in the same cycle, the read still returns its data, but the free takes priority and the entry is gone afterwards.
- R8: `wb_ready` is always 1. A write-back has no effect unless `wb_valid` is high.
- R9: After reset, no register is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Write-back offered |
| wb_ready | output | 1 | Write-back accepted (constant 1) |
| wb_preg | input | 6 | Physical register number of the write-back |
| wb_data | input | 32 | Value written back |
| wb_pred | input | 4 | Predicted consumer count |
| wb_byp | input | 4 | Consumers already served by the bypass network |
| wb_set | input | 2 | Target set from the external allocator |
| rd_valid | input | 2 | One read strobe per port |
| rd_preg | input | 12 | Register number per port, port p at bits [6p+5:6p] |
| rd_hit | output | 2 | Hit flag per port |
| rd_data | output | 64 | Data per port, port p at bits [32p+31:32p] |
| free_valid | input | 1 | Release strobe |
| free_preg | input | 6 | Register being released |

## Verification
The bench runs every combination of predicted and bypassed counts, then reads each register until it misses and compares the number of hits with the saturating difference. A design that inserted values with nothing left to consume, or that did not saturate at zero, would report extra hits. Directed sequences fill a set and then insert into it, to check three things:
- The smaller count loses, so a design that used recency would evict the wrong register.
- A tie goes to way 0.
- A freed way is refilled without evicting anything, so a design that ignored invalid ways would lose a live register.

Two further cases are checked: two ports reading one register in the same cycle, which must cost two uses, and a free that lands in the same cycle as a read, which must leave the register gone afterwards.

// File: rtl/regcache_pkg.sv
package regcache_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] ucnt_t;

  // consumers left after the bypass network, floored at zero
  function automatic ucnt_t left_uses(ucnt_t pred, ucnt_t byp);
    return (pred > byp) ? ucnt_t'(pred - byp) : '0;
  endfunction
endpackage

// File: rtl/rc_way_match.sv
module rc_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  parameter int WIW   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TAG_W-1:0]      key,
  input  logic [WAYS-1:0]       way_vld,
  input  logic [WAYS*TAG_W-1:0] way_tag,
  output logic                  hit,
  output logic [WIW-1:0]        way
);
  logic [WAYS-1:0] match;

  always_comb begin
    match = '0;
    way   = '0;
    for (int w = 0; w < WAYS; w++)
      match[w] = way_vld[w] && (way_tag[w*TAG_W +: TAG_W] == key);
    for (int w = 0; w < WAYS; w++)
      if (match[w]) way = WIW'(w);
    hit = |match;
  end

  // R2: a register never sits in two ways of one set
  assert_unique_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/rc_victim_pick.sv
module rc_victim_pick
  import regcache_pkg::*;
#(
  parameter int WAYS = 2,
  parameter int WIW  = 1
) (
  input  logic [WAYS-1:0]       way_vld,
  input  logic [WAYS*CNT_W-1:0] way_cnt,
  output logic [WIW-1:0]        way
);
  logic  found;
  ucnt_t best;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = way_cnt[CNT_W-1:0];
    for (int w = 0; w < WAYS; w++)
      if (!way_vld[w] && !found) begin
        found = 1'b1;
        way   = WIW'(w);
      end
    if (!found)
      for (int w = 1; w < WAYS; w++)
        if (way_cnt[w*CNT_W +: CNT_W] < best) begin
          best = way_cnt[w*CNT_W +: CNT_W];
          way  = WIW'(w);
        end
  end
endmodule

// File: rtl/regcache_usecount.sv
module regcache_usecount
  import regcache_pkg::*;
#(
  parameter int SETS     = 4,
  parameter int WAYS     = 2,
  parameter int RD_PORTS = 2,
  parameter int PREGS    = 64,
  parameter int DATA_W   = 32,
  localparam int PREG_W  = $clog2(PREGS),
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wb_valid,
  output logic                       wb_ready,
  input  logic [PREG_W-1:0]          wb_preg,
  input  logic [DATA_W-1:0]          wb_data,
  input  logic [CNT_W-1:0]           wb_pred,
  input  logic [CNT_W-1:0]           wb_byp,
  input  logic [SET_W-1:0]           wb_set,
  input  logic [RD_PORTS-1:0]        rd_valid,
  input  logic [RD_PORTS*PREG_W-1:0] rd_preg,
  output logic [RD_PORTS-1:0]        rd_hit,
  output logic [RD_PORTS*DATA_W-1:0] rd_data,
  input  logic                       free_valid,
  input  logic [PREG_W-1:0]          free_preg
);
  localparam int ENTRIES = SETS * WAYS;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int WIW     = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int NL      = RD_PORTS + 1;   // read lookups plus the free lookup

  // entry storage, index = set*WAYS + way
  logic [ENTRIES-1:0] e_vld, n_vld;
  logic [PREG_W-1:0]  e_tag  [ENTRIES];
  logic [PREG_W-1:0]  n_tag  [ENTRIES];
  ucnt_t              e_cnt  [ENTRIES];
  ucnt_t              n_cnt  [ENTRIES];
  logic [DATA_W-1:0]  e_data [ENTRIES];
  logic [DATA_W-1:0]  n_data [ENTRIES];
  logic [SET_W-1:0]   set_map [PREGS];

  logic [NL-1:0]    lk_hit;
  logic [WIW-1:0]   lk_way [NL];
  logic [SET_W-1:0] lk_set [NL];
  logic [IDX_W-1:0] lk_idx [NL];

  assign wb_ready = 1'b1;

  // one tag lookup per read port, the last one serves the free port
  for (genvar l = 0; l < NL; l++) begin : g_lookup
    logic [PREG_W-1:0]      key;
    logic [WAYS-1:0]        vf;
    logic [WAYS*PREG_W-1:0] tf;
    if (l < RD_PORTS) begin : g_rd
      assign key = rd_preg[l*PREG_W +: PREG_W];
    end else begin : g_fr
      assign key = free_preg;
    end
    assign lk_set[l] = set_map[key];
    always_comb
      for (int w = 0; w < WAYS; w++) begin
        vf[w]                    = e_vld[IDX_W'(int'(lk_set[l]) * WAYS + w)];
        tf[w*PREG_W +: PREG_W]   = e_tag[IDX_W'(int'(lk_set[l]) * WAYS + w)];
      end
    assign lk_idx[l] = IDX_W'(int'(lk_set[l]) * WAYS + int'(lk_way[l]));
    rc_way_match #(.WAYS(WAYS), .TAG_W(PREG_W), .WIW(WIW)) u_match (
      .clk(clk), .rst_n(rst_n), .key(key), .way_vld(vf), .way_tag(tf),
      .hit(lk_hit[l]), .way(lk_way[l]));
  end

  always_comb
    for (int p = 0; p < RD_PORTS; p++) begin
      rd_hit[p] = rd_valid[p] & lk_hit[p];
      rd_data[p*DATA_W +: DATA_W] = rd_hit[p] ? e_data[lk_idx[p]] : '0;
    end

  logic             fr_hit;
  logic [IDX_W-1:0] fr_idx;
  assign fr_hit = free_valid & lk_hit[RD_PORTS];
  assign fr_idx = lk_idx[RD_PORTS];

  // victim choice inside the allocator's set
  logic [WAYS-1:0]       vs_vld;
  logic [WAYS*CNT_W-1:0] vs_cnt;
  logic [WIW-1:0]        vic_way;
  always_comb
    for (int w = 0; w < WAYS; w++) begin
      vs_vld[w]                  = e_vld[IDX_W'(int'(wb_set) * WAYS + w)];
      vs_cnt[w*CNT_W +: CNT_W]   = e_cnt[IDX_W'(int'(wb_set) * WAYS + w)];
    end

  rc_victim_pick #(.WAYS(WAYS), .WIW(WIW)) u_victim (
    .way_vld(vs_vld), .way_cnt(vs_cnt), .way(vic_way));

  ucnt_t            ins_cnt;
  logic             ins_en;
  logic [IDX_W-1:0] ins_idx;
  assign ins_cnt = left_uses(wb_pred, wb_byp);
  assign ins_en  = wb_valid && (ins_cnt != '0);
  assign ins_idx = IDX_W'(int'(wb_set) * WAYS + int'(vic_way));

  // next state: consume uses, then free, then insert
  always_comb begin
    int dec;
    n_vld  = e_vld;
    n_tag  = e_tag;
    n_cnt  = e_cnt;
    n_data = e_data;
    for (int i = 0; i < ENTRIES; i++) begin
      dec = 0;
      for (int p = 0; p < RD_PORTS; p++)
        if (rd_hit[p] && lk_idx[p] == IDX_W'(i)) dec++;
      if (e_vld[i] && dec > 0) begin
        if (dec >= int'(e_cnt[i])) n_vld[i] = 1'b0;
        else n_cnt[i] = e_cnt[i] - CNT_W'(dec);
      end
    end
    if (fr_hit) n_vld[fr_idx] = 1'b0;
    if (ins_en) begin
      n_vld[ins_idx]  = 1'b1;
      n_tag[ins_idx]  = wb_preg;
      n_cnt[ins_idx]  = ins_cnt;
      n_data[ins_idx] = wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_tag[i]  <= '0;
        e_cnt[i]  <= '0;
        e_data[i] <= '0;
      end
      for (int r = 0; r < PREGS; r++) set_map[r] <= '0;
    end else begin
      e_vld  <= n_vld;
      e_tag  <= n_tag;
      e_cnt  <= n_cnt;
      e_data <= n_data;
      if (ins_en) set_map[wb_preg] <= wb_set;
    end
  end

  // checker support
  logic set_has_free, vic_min_ok;
  int   hits_on0;
  always_comb begin
    set_has_free = ~&vs_vld;
    vic_min_ok   = 1'b1;
    for (int w = 0; w < WAYS; w++)
      if (vs_cnt[w*CNT_W +: CNT_W] < vs_cnt[int'(vic_way)*CNT_W +: CNT_W]) vic_min_ok = 1'b0;
    hits_on0 = 0;
    for (int p = 0; p < RD_PORTS; p++)
      if (rd_hit[p] && lk_idx[p] == lk_idx[0]) hits_on0++;
  end

  // R1: a fully bypassed write-back never adds a resident entry
  assert_skip_insert_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_pred <= wb_byp) |=> ($countones(e_vld) <= $past($countones(e_vld))));

  // R3: with an invalid way present, a valid way is never chosen
  assert_fill_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && set_has_free) |-> !vs_vld[vic_way]);

  // R4: in a full set the victim holds the smallest count
  assert_victim_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !set_has_free) |-> vic_min_ok);

  // R6: one hit costs exactly one use
  assert_one_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit[0] && hits_on0 == 1 && e_cnt[lk_idx[0]] > 1
     && !(fr_hit && fr_idx == lk_idx[0]) && !(ins_en && ins_idx == lk_idx[0]))
    |=> (e_vld[$past(lk_idx[0])] && e_cnt[$past(lk_idx[0])] == $past(e_cnt[lk_idx[0]]) - 4'd1));

  // R7: a free wins over a same-cycle read
  assert_free_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_hit && !(ins_en && ins_idx == fr_idx)) |=> !e_vld[$past(fr_idx)]);
endmodule

// File: tb/tb_regcache_usecount.sv
`timescale 1ns/1ps
module tb_regcache_usecount;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_valid = 1'b0;
  logic        wb_ready;
  logic [5:0]  wb_preg = '0;
  logic [31:0] wb_data = '0;
  logic [3:0]  wb_pred = '0;
  logic [3:0]  wb_byp = '0;
  logic [1:0]  wb_set = '0;
  logic [1:0]  rd_valid = '0;
  logic [11:0] rd_preg = '0;
  logic [1:0]  rd_hit;
  logic [63:0] rd_data;
  logic        free_valid = 1'b0;
  logic [5:0]  free_preg = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  regcache_usecount dut (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_preg(wb_preg), .wb_data(wb_data), .wb_pred(wb_pred), .wb_byp(wb_byp),
    .wb_set(wb_set), .rd_valid(rd_valid), .rd_preg(rd_preg), .rd_hit(rd_hit),
    .rd_data(rd_data), .free_valid(free_valid), .free_preg(free_preg));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic wb(input logic [5:0] p, input logic [31:0] d,
                    input logic [3:0] pr, input logic [3:0] by, input logic [1:0] s);
    wb_valid = 1'b1; wb_preg = p; wb_data = d; wb_pred = pr; wb_byp = by; wb_set = s;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic rd0(input logic [5:0] p, output bit h, output logic [31:0] d);
    rd_valid = 2'b01; rd_preg[5:0] = p;
    #1;
    h = rd_hit[0]; d = rd_data[31:0];
    @(negedge clk);
    rd_valid = 2'b00;
  endtask

  task automatic drain(input logic [5:0] p, output int n, output logic [31:0] first);
    bit h;
    logic [31:0] d;
    n = 0; first = '0;
    for (int i = 0; i < 20; i++) begin
      rd0(p, h, d);
      if (!h) break;
      if (n == 0) first = d;
      n++;
    end
  endtask

  task automatic free_reg(input logic [5:0] p);
    free_valid = 1'b1; free_preg = p;
    @(negedge clk);
    free_valid = 1'b0;
  endtask

  task automatic expect_uses(input logic [5:0] p, input int exp, input string req);
    int n;
    logic [31:0] f;
    drain(p, n, f);
    chk(n == exp, req, $sformatf("uses of reg %0d", p), n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit h, h1;
    logic [31:0] d, d1;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9, R5: nothing resident after reset, miss data zero
    for (int r = 0; r < 64; r++) begin
      rd0(6'(r), h, d);
      chk(h == 0 && d == 0, "R9", $sformatf("reset read reg %0d", r), {h, d}, 0);
    end
    // R8
    chk(wb_ready == 1'b1, "R8", "wb_ready", wb_ready, 1);

    // R1, R6: sweep every predicted/bypassed pair
    for (int pr = 0; pr < 16; pr++)
      for (int by = 0; by < 16; by++) begin
        int exp;
        logic [5:0] p;
        logic [31:0] dv;
        exp = (pr > by) ? pr - by : 0;
        p = 6'((pr * 16 + by) % 64);
        dv = 32'hA500_0000 | (pr << 8) | by;
        wb(p, dv, 4'(pr), 4'(by), 2'((pr + by) % 4));
        drain(p, n, d);
        chk(n == exp, "R1", $sformatf("hits pred=%0d byp=%0d", pr, by), n, exp);
        if (exp > 0) chk(d == dv, "R2", "data returned", d, dv);
      end

    // R2: same low bits, different sets, all resident
    wb(6'd4, 32'h1111, 4'd1, 4'd0, 2'd0);
    wb(6'd8, 32'h2222, 4'd1, 4'd0, 2'd1);
    wb(6'd12, 32'h3333, 4'd1, 4'd0, 2'd2);
    wb(6'd16, 32'h4444, 4'd1, 4'd0, 2'd0);
    expect_uses(6'd4, 1, "R2");
    expect_uses(6'd8, 1, "R2");
    expect_uses(6'd12, 1, "R2");
    expect_uses(6'd16, 1, "R2");

    // R4: smallest count is evicted
    wb(6'd11, 32'hB1, 4'd3, 4'd0, 2'd2);
    wb(6'd21, 32'hB2, 4'd2, 4'd0, 2'd2);
    wb(6'd31, 32'hB3, 4'd5, 4'd0, 2'd2);
    expect_uses(6'd21, 0, "R4");
    expect_uses(6'd11, 3, "R4");
    expect_uses(6'd31, 5, "R4");

    // R4: tie goes to way 0 (first inserted)
    wb(6'd10, 32'hC1, 4'd2, 4'd0, 2'd1);
    wb(6'd20, 32'hC2, 4'd2, 4'd0, 2'd1);
    wb(6'd30, 32'hC3, 4'd1, 4'd0, 2'd1);
    expect_uses(6'd10, 0, "R4");
    expect_uses(6'd20, 2, "R4");
    expect_uses(6'd30, 1, "R4");

    // R3: freed way is refilled, low-count neighbour survives
    wb(6'd33, 32'hD1, 4'd4, 4'd0, 2'd3);
    wb(6'd34, 32'hD2, 4'd1, 4'd0, 2'd3);
    free_reg(6'd33);
    wb(6'd35, 32'hD3, 4'd6, 4'd0, 2'd3);
    expect_uses(6'd34, 1, "R3");
    expect_uses(6'd35, 6, "R3");
    expect_uses(6'd33, 0, "R3");

    // R6: two ports on one register cost two uses
    wb(6'd50, 32'hE50, 4'd3, 4'd0, 2'd2);
    rd_valid = 2'b11; rd_preg = {6'd50, 6'd50};
    #1;
    h = rd_hit[0]; h1 = rd_hit[1]; d = rd_data[31:0]; d1 = rd_data[63:32];
    @(negedge clk);
    rd_valid = 2'b00;
    chk(h && h1 && d == 32'hE50 && d1 == 32'hE50, "R6", "dual hit", {h, h1}, 3);
    expect_uses(6'd50, 1, "R6");

    // R6: two ports on different registers each cost one
    wb(6'd51, 32'hE51, 4'd2, 4'd0, 2'd0);
    wb(6'd52, 32'hE52, 4'd3, 4'd0, 2'd1);
    rd_valid = 2'b11; rd_preg = {6'd52, 6'd51};
    #1;
    chk(rd_hit == 2'b11 && rd_data == {32'hE52, 32'hE51}, "R6", "split hit", rd_data, {32'hE52, 32'hE51});
    @(negedge clk);
    rd_valid = 2'b00;
    expect_uses(6'd51, 1, "R6");
    expect_uses(6'd52, 2, "R6");

    // R7: free alone
    wb(6'd53, 32'hF53, 4'd4, 4'd0, 2'd3);
    free_reg(6'd53);
    expect_uses(6'd53, 0, "R7");

    // R7: free and read in the same cycle
    wb(6'd54, 32'hF54, 4'd5, 4'd0, 2'd0);
    rd_valid = 2'b01; rd_preg[5:0] = 6'd54; free_valid = 1'b1; free_preg = 6'd54;
    #1;
    chk(rd_hit[0] && rd_data[31:0] == 32'hF54, "R7", "read during free", rd_data[31:0], 32'hF54);
    @(negedge clk);
    rd_valid = 2'b00; free_valid = 1'b0;
    expect_uses(6'd54, 0, "R7");

    // R8: write-back fields without valid do nothing
    wb_preg = 6'd55; wb_data = 32'h55; wb_pred = 4'd7; wb_byp = 4'd0; wb_set = 2'd1;
    @(negedge clk);
    expect_uses(6'd55, 0, "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule